// File: doc/BRIEF.md
# Prescaled Tick-Driven PWM Generator

This block drives one pulse-width-modulated output from a slow tick enable (nominally 32 kHz) supplied by the surrounding chip. An 8-bit counter advances once per tick. A 2-bit prescale field selects which counter bit acts as the wrap bit. When the incremented count would set that bit, the counter goes back to zero. The four settings therefore give periods of 128, 64, 32 and 16 ticks. A duty value gives the number of ticks at the start of each period during which the output is high.

Software programs the block through an 8-bit register port. The port has an address, a write strobe, write data and combinational read data. Address 0 is the control register: the enable is bit 7 and the prescale field is bits 1:0. Address 1 is the duty register, and bits 6:0 hold the duty value. Prescale and duty changes take effect at once. Neither change waits for a period boundary or clears the counter.

A two-state machine sequences the channel. In ST_OFF the counter is held at zero and the output is low. The transition ST_OFF→ST_RUN is taken on the clock after the enable bit reads 1. In ST_RUN the counter advances on ticks and the output compares the count against the duty value. The transition ST_RUN→ST_OFF is taken on the clock after the enable bit reads 0.

Top module: `slow_pwm`

## Requirements
- R1: After reset both registers read 0x00, the state is ST_OFF and the output is low.
- R2: Address 0 reads back {enable, 5'b0, prescale}. Enable is bit 7 and prescale is bits 1:0. Written values in bits 6:2 are ignored and read as zero.
- R3: Address 1 reads back {1'b0, duty}, with the duty value in bits 6:0. A written bit 7 is ignored and reads as zero.
- R4: With prescale p, a tick in ST_RUN increments the counter. The counter returns to zero if bit 7−p of the incremented value is set. The periods are 128, 64, 32 and 16 ticks for p = 0, 1, 2 and 3.
- R5: In ST_RUN the output is high exactly while count < duty. A duty value at or above the period length keeps the output high for the whole period. For example, p=1 with duty 64 is constantly high.
- R6: With p=0 the largest duty value is 127, so the output is low for exactly 1 tick in every 128.
- R7: In ST_OFF the output is low and the counter is cleared. ST_OFF→ST_RUN and ST_RUN→ST_OFF each follow the enable bit one clock later. Every run therefore starts from count 0 with the output high if duty > 0.
- R8: Changing the prescale field does not reset the counter. A count above the new range keeps counting until its new wrap bit would set.
- R9: A new duty value takes effect in the clock cycle right after the write, inside the current period.
- R10: The counter changes only on clocks with the tick enable high, or when it is cleared in ST_OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow tick enable; the counter advances on clocks where it is high |
| reg_addr_i | input | 1 | Register select: 0 control, 1 duty |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Combinational read data for reg_addr_i |
| pwm_o | output | 1 | PWM output |

## Verification
A wrong count or wrong wrap bit shows at pwm_o as a high/low edge that comes a tick early or late. Such an error becomes visible within one period at the latest, and only when the duty value falls inside the counted range. A stuck or late state machine shows as output activity while disabled, or as a first high phase that does not start from count 0. Both show within two clocks of the control write. The reference model tracks register contents, state and count tick by tick, so any divergence is reported on the clock it reaches a port. Directed cases add the prescale switch in mid-count and the duty change in mid-period, where a design that realigns to the period boundary produces a different output on the very next clock.

// File: rtl/slow_pwm_pkg.sv
package slow_pwm_pkg;
    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } pwm_state_e;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DUTY = 1'b1;
endpackage

// File: rtl/slow_pwm_regs.sv
module slow_pwm_regs #(
    parameter int DATA_W = 8,
    parameter int PSC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              en_o,
    output logic [PSC_W-1:0]  psc_o,
    output logic [DATA_W-2:0] duty_o
);
    import slow_pwm_pkg::*;

    localparam int EN_BIT = DATA_W - 1;
    localparam int PAD_W  = DATA_W - 1 - PSC_W;

    logic              en_q;
    logic [PSC_W-1:0]  psc_q;
    logic [DATA_W-2:0] duty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            psc_q  <= '0;
            duty_q <= '0;
        end else if (wr_i) begin
            if (addr_i == ADDR_CTRL) begin
                en_q  <= wdata_i[EN_BIT];
                psc_q <= wdata_i[PSC_W-1:0];
            end else begin
                duty_q <= wdata_i[DATA_W-2:0];
            end
        end
    end

    always_comb begin
        if (addr_i == ADDR_CTRL) rdata_o = {en_q, {PAD_W{1'b0}}, psc_q};
        else                     rdata_o = {1'b0, duty_q};
    end

    assign en_o   = en_q;
    assign psc_o  = psc_q;
    assign duty_o = duty_q;
endmodule

// File: rtl/slow_pwm_counter.sv
module slow_pwm_counter #(
    parameter int CNT_W = 8,
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] wrap_mask;

    // Wrap bit index is CNT_W-1-psc: a one-hot mask shifted down by the prescale.
    assign wrap_mask = {1'b1, {(CNT_W-1){1'b0}}} >> psc_i;
    assign inc       = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (clr_i)                     cnt_q <= '0;
        else if (tick_i) begin
            if ((inc & wrap_mask) != '0)    cnt_q <= '0;
            else                            cnt_q <= inc;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/slow_pwm_fsm.sv
module slow_pwm_fsm #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-2:0] duty_i,
    output logic             run_o,
    output logic             pwm_o
);
    import slow_pwm_pkg::*;

    pwm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (en_i)  state_d = ST_RUN;
            ST_RUN: if (!en_i) state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        run_o = 1'b0;
        pwm_o = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                run_o = 1'b0;
                pwm_o = 1'b0;
            end
            ST_RUN: begin
                run_o = 1'b1;
                pwm_o = (cnt_i < {1'b0, duty_i});
            end
        endcase
    end
endmodule

// File: rtl/slow_pwm.sv
module slow_pwm #(
    parameter int CNT_W = 8,
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             reg_addr_i,
    input  logic             reg_wr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    output logic             pwm_o
);
    logic             en_w;
    logic             run_w;
    logic [PSC_W-1:0] psc_w;
    logic [CNT_W-2:0] duty_w;
    logic [CNT_W-1:0] cnt_w;

    slow_pwm_regs #(.DATA_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr_i),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .en_o    (en_w),
        .psc_o   (psc_w),
        .duty_o  (duty_w)
    );

    slow_pwm_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!run_w),
        .tick_i (tick_i),
        .psc_i  (psc_w),
        .cnt_o  (cnt_w)
    );

    slow_pwm_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_w),
        .cnt_i  (cnt_w),
        .duty_i (duty_w),
        .run_o  (run_w),
        .pwm_o  (pwm_o)
    );
endmodule

// File: rtl/slow_pwm_chk.sv
module slow_pwm_chk #(
    parameter int CNT_W = 8,
    parameter int PSC_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-2:0] duty,
    input logic [PSC_W-1:0] psc,
    input logic             addr,
    input logic [CNT_W-1:0] rdata,
    input logic             pwm
);
    localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << (CNT_W-1);

    logic [CNT_W:0] last_cnt;
    assign last_cnt = (FULL >> psc) - (CNT_W+1)'(1);

    // R7
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm);

    // R7
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt == $past(cnt)));

    // R4
    period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && ({1'b0, cnt} == last_cnt)) |=> (cnt == '0));

    // R5
    high_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ({1'b0, cnt} < {2'b00, duty})) |-> pwm);

    // R2
    ctrl_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 1'b0) |-> (rdata[CNT_W-2:PSC_W] == '0));

    // R3
    duty_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 1'b1) |-> !rdata[CNT_W-1]);
endmodule

bind slow_pwm slow_pwm_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_i),
    .run   (run_w),
    .cnt   (cnt_w),
    .duty  (duty_w),
    .psc   (psc_w),
    .addr  (reg_addr_i),
    .rdata (reg_rdata_o),
    .pwm   (pwm_o)
);

// File: tb/slow_pwm_tb.sv
`timescale 1ns/1ps
module slow_pwm_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       addr = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       pwm;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    slow_pwm u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pwm_o       (pwm)
    );

    // Behavioural reference state
    bit m_en;
    int m_psc;
    int m_duty;
    bit m_run;
    int m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_psc = 0; m_duty = 0; m_run = 0; m_cnt = 0;
        end else begin
            if (!m_run) m_cnt = 0;
            else if (tick) begin
                m_cnt = m_cnt + 1;
                if ((m_cnt & (128 >> m_psc)) != 0) m_cnt = 0;
            end
            m_run = m_en;
            if (wr) begin
                if (addr == 1'b0) begin
                    m_en  = wdata[7];
                    m_psc = int'(wdata[1:0]);
                end else begin
                    m_duty = int'(wdata[6:0]);
                end
            end
        end
    end

    function automatic logic [7:0] exp_rd(input logic a);
        if (a == 1'b0) return {m_en, 5'b0, 2'(m_psc)};
        return {1'b0, 7'(m_duty)};
    endfunction

    function automatic logic exp_pwm();
        return m_run && (m_cnt < m_duty);
    endfunction

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (pwm !== exp_pwm()) begin
                n_bad++;
                $display("FAIL R5 pwm_o model compare t=%0t actual=%0b expected=%0b", $time, pwm, exp_pwm());
            end
            n_cmp++;
            if (rdata !== exp_rd(addr)) begin
                n_bad++;
                $display("FAIL R2 read data model compare addr=%0b actual=%02h expected=%02h", addr, rdata, exp_rd(addr));
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic read_at(input logic a, output logic [7:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic measure(input int p, input int d, input int exp_hi, input string tag);
        int hi;
        reg_write(1'b1, 8'(d));
        reg_write(1'b0, 8'h80 | 8'(p));
        tick = 1'b1;
        repeat (256) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            if (pwm) hi++;
        end
        check(tag, hi, exp_hi);
    endtask

    initial begin
        #(5.0 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int toggles;
        logic prev;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_at(1'b0, v); check("R1 ctrl after reset", int'(v), 0);
        read_at(1'b1, v); check("R1 duty after reset", int'(v), 0);
        check("R1 output after reset", int'(pwm), 0);

        // R2 / R3 read-back masking
        reg_write(1'b0, 8'h7E);
        read_at(1'b0, v); check("R2 ctrl pad bits ignored", int'(v), 8'h02);
        reg_write(1'b1, 8'hFF);
        read_at(1'b1, v); check("R3 duty bit7 ignored", int'(v), 8'h7F);
        reg_write(1'b0, 8'h00);

        // R4 / R5 / R6 high-tick counts over a 128-tick window
        measure(3, 5,   40,  "R4 p3 duty5 high ticks");
        measure(2, 0,   0,   "R5 p2 duty0 high ticks");
        measure(2, 20,  80,  "R4 p2 duty20 high ticks");
        measure(1, 64,  128, "R5 p1 duty64 constant high");
        measure(3, 100, 128, "R5 duty above period stays high");
        measure(0, 127, 127, "R6 p0 duty127 one low tick");

        // R7 disable then enable from count zero
        reg_write(1'b0, 8'h00);
        @(negedge clk);
        check("R7 disabled output low", int'(pwm), 0);
        reg_write(1'b1, 8'd1);
        reg_write(1'b0, 8'h83);
        @(negedge clk);
        check("R7 first tick of run high", int'(pwm), 1);
        @(negedge clk);
        check("R7 second tick low with duty1", int'(pwm), 0);

        // R8 prescale change keeps the count
        reg_write(1'b0, 8'h00);
        reg_write(1'b1, 8'd16);
        reg_write(1'b0, 8'h80);
        repeat (40) @(negedge clk);
        reg_write(1'b0, 8'h83);
        check("R8 prescale switch keeps high count", int'(pwm), 0);
        repeat (40) @(negedge clk);

        // R9 duty change in mid-period
        reg_write(1'b0, 8'h00);
        reg_write(1'b1, 8'd0);
        reg_write(1'b0, 8'h80);
        repeat (10) @(negedge clk);
        check("R9 low before duty write", int'(pwm), 0);
        reg_write(1'b1, 8'd50);
        check("R9 high right after duty write", int'(pwm), 1);

        // R10 no ticks, no movement
        reg_write(1'b1, 8'd8);
        reg_write(1'b0, 8'h83);
        repeat (5) @(negedge clk);
        tick = 1'b0;
        prev = pwm;
        toggles = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (pwm !== prev) toggles++;
            prev = pwm;
        end
        check("R10 output frozen without ticks", toggles, 0);

        // Mixed stimulus: sparse ticks and random writes, model compare each clock
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            tick = (($urandom % 3) == 0);
            if (($urandom % 12) == 0) begin
                addr = 1'($urandom);
                wdata = 8'($urandom);
                wr = 1'b1;
            end else begin
                wr = 1'b0;
                addr = 1'($urandom);
            end
        end
        @(negedge clk);
        wr = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule